// File: doc/BRIEF.md
# Branch Target Buffer with Wrong-Target Promotion

This block is a set-associative branch target buffer for a fetch pipeline. Each entry keeps a tag, a type bit marking indirect branches, the last resolved target, and a saturating-free counter of how often the stored target turned out to be wrong. The fetch side presents a PC and receives a hit flag, the stored target and an always-taken indication for indirect branches. The resolve side presents each retired branch with its actual target and direction, and the block fills, retargets or promotes entries from that stream.

Branches whose targets keep changing are poor tenants of a conventional target buffer. When an entry's wrong-target count reaches a threshold, the block emits that branch's tag and latest target on a promotion port for a separate small buffer, frees the entry and zeroes its count. The caller may also steer both lookup and update to an explicit set and way (a rehashed location) instead of the PC-derived set, and may flag a branch as already held by the promotion buffer so it is not allocated again.

Top module: `btb_promo`

## Requirements
- R1: After reset no entry is valid: every lookup reports a miss with target zero, and the promotion output is low.
- R2: Without a rehash request, the set index is PC bits [IDX_LO +: SET_W] and the tag is the PC bits above them; a lookup hits when a valid entry of that set holds the tag, and the hit and stored target appear combinationally in the same cycle.
- R3: A taken resolved branch that hits an entry whose stored target differs from the actual target increments that entry's counter by one and replaces the stored target with the actual one; a hit with the correct target, or a not-taken hit, leaves the counter unchanged.
- R4: When a wrong-target hit brings the counter to PROMO_THRESH, the next cycle shows the promotion output valid for one cycle with the entry's tag and the actual target; the entry is then invalid with its counter at zero, and it is not refilled in that cycle.
- R5: The always-taken output is 1 exactly when a lookup hits an entry whose type bit is 1 (indirect branch); a conditional entry (type bit 0) gives 0.
- R6: When the rehash enable is set, lookup or update uses the supplied set and way in place of the PC-derived set, still requiring the tag to match for a hit; a miss that fills goes into that supplied way.
- R7: A taken miss flagged as already present in the promotion buffer allocates nothing.
- R8: A taken miss (without rehash) fills the least recently used way of its set; every hit and every fill makes the touched way the most recently used.
- R9: A fill stores tag, target and type bit and starts the counter at zero.
- R10: A not-taken miss allocates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Fetch PC to look up |
| lk_rh_en | input | 1 | Use the supplied set/way for the lookup |
| lk_rh_set | input | SET_W | Rehashed set for the lookup |
| lk_rh_way | input | WAY_W | Rehashed way for the lookup |
| lk_hit | output | 1 | Lookup found a matching valid entry |
| lk_always_taken | output | 1 | Hit on an indirect entry: predict taken |
| lk_target | output | PC_W | Stored target on a hit, zero otherwise |
| up_valid | input | 1 | A resolved branch is presented |
| up_pc | input | PC_W | PC of the resolved branch |
| up_target | input | PC_W | Actual target |
| up_taken | input | 1 | Branch was taken |
| up_indirect | input | 1 | Branch is indirect (type bit for a fill) |
| up_promoted | input | 1 | Branch already lives in the promotion buffer |
| up_rh_en | input | 1 | Use the supplied set/way for the update |
| up_rh_set | input | SET_W | Rehashed set for the update |
| up_rh_way | input | WAY_W | Rehashed way for the update |
| pm_valid | output | 1 | Promotion event, one cycle |
| pm_tag | output | TAG_W | Tag of the promoted branch |
| pm_target | output | PC_W | Latest target of the promoted branch |

## Verification
On every cycle the assertions check that a retarget raises the stored counter by exactly one, that a promotion leaves its entry invalid with a zero counter while the promotion output is high, that a fill leaves a valid entry with a zero counter, that the recency ages of each accessed set keep exactly one oldest way, that an always-taken indication implies a hit and that a flagged branch is never allocated. Only the bench scenarios can show the end-to-end orderings: which tag the replacement evicts after a mix of hits and fills, that promotion happens on exactly the threshold-th wrong target and not before, that correct-target hits do not advance the count, and that rehashed locations are invisible to plain PC lookup.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Action taken by the resolve port in a cycle
  typedef enum logic [1:0] {
    BK_IDLE     = 2'd0,
    BK_HIT      = 2'd1,   // hit, counter untouched
    BK_RETARGET = 2'd2,   // hit with a wrong stored target
    BK_FILL     = 2'd3    // allocation on a taken miss
  } bk_op_e;

endpackage

// File: rtl/btb_way_match.sv
module btb_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);

  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = vld[g] && (tags[g] == tag);
  end

  // lowest matching way wins
  always_comb begin
    hit_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) hit_way = WAY_W'(i);
    end
  end

  assign hit = |match;

endmodule

// File: rtl/btb_lru_bank.sv
module btb_lru_bank #(
  parameter int SETS = 512,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] victim_way,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way
);

  // age 0 = most recent, WAYS-1 = least recent; each set holds a permutation
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] age_d [SETS][WAYS];
  logic [WAY_W-1:0] ref_age;
  logic [WAYS-1:0]  oldest;

  always_comb begin
    age_d   = age_q;
    ref_age = age_q[touch_set][touch_way];
    if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_d[touch_set][w] = '0;
        else if (age_q[touch_set][w] < ref_age)
          age_d[touch_set][w] = age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      age_q <= age_d;
    end
  end

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      oldest[w] = (age_q[rd_set][w] == WAY_W'(WAYS - 1));
      if (oldest[w]) victim_way = WAY_W'(w);
    end
  end

  // R8: the ages of a set stay a permutation, so exactly one way is oldest
  p_lru_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1);

endmodule

// File: rtl/btb_promo.sv
module btb_promo
  import btb_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int SETS         = 512,
  parameter int WAYS         = 4,
  parameter int PROMO_THRESH = 512,
  parameter int IDX_LO       = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = PC_W - IDX_LO - SET_W,
  localparam int TMC_W = $clog2(PROMO_THRESH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic             lk_rh_en,
  input  logic [SET_W-1:0] lk_rh_set,
  input  logic [WAY_W-1:0] lk_rh_way,
  output logic             lk_hit,
  output logic             lk_always_taken,
  output logic [PC_W-1:0]  lk_target,
  input  logic             up_valid,
  input  logic [PC_W-1:0]  up_pc,
  input  logic [PC_W-1:0]  up_target,
  input  logic             up_taken,
  input  logic             up_indirect,
  input  logic             up_promoted,
  input  logic             up_rh_en,
  input  logic [SET_W-1:0] up_rh_set,
  input  logic [WAY_W-1:0] up_rh_way,
  output logic             pm_valid,
  output logic [TAG_W-1:0] pm_tag,
  output logic [PC_W-1:0]  pm_target
);

  // ---------------- entry storage ----------------
  logic             vld_q [SETS][WAYS];
  logic [TMC_W-1:0] tmc_q [SETS][WAYS];
  logic             ind_q [SETS][WAYS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PC_W-1:0]  tgt_q [SETS][WAYS];

  // ---------------- lookup path ----------------
  logic [SET_W-1:0]            lk_pset;
  logic [TAG_W-1:0]            lk_tag;
  logic [WAYS-1:0]             lk_vvec;
  logic [WAYS-1:0][TAG_W-1:0]  lk_tvec;
  logic                        lk_mhit;
  logic [WAY_W-1:0]            lk_mway;
  logic [SET_W-1:0]            lk_set;
  logic [WAY_W-1:0]            lk_way;

  assign lk_pset = lk_pc[IDX_LO +: SET_W];
  assign lk_tag  = lk_pc[PC_W-1 -: TAG_W];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_vvec[w] = vld_q[lk_pset][w];
      lk_tvec[w] = tag_q[lk_pset][w];
    end
  end

  btb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .vld(lk_vvec), .tags(lk_tvec), .tag(lk_tag),
    .hit(lk_mhit), .hit_way(lk_mway)
  );

  always_comb begin
    if (lk_rh_en) begin
      lk_set = lk_rh_set;
      lk_way = lk_rh_way;
      lk_hit = vld_q[lk_rh_set][lk_rh_way] && (tag_q[lk_rh_set][lk_rh_way] == lk_tag);
    end else begin
      lk_set = lk_pset;
      lk_way = lk_mway;
      lk_hit = lk_mhit;
    end
    lk_target       = lk_hit ? tgt_q[lk_set][lk_way] : '0;
    lk_always_taken = lk_hit && ind_q[lk_set][lk_way];
  end

  // ---------------- resolve path ----------------
  logic [SET_W-1:0]            up_pset;
  logic [TAG_W-1:0]            up_tag;
  logic [WAYS-1:0]             up_vvec;
  logic [WAYS-1:0][TAG_W-1:0]  up_tvec;
  logic                        up_mhit;
  logic [WAY_W-1:0]            up_mway;
  logic [WAY_W-1:0]            victim;
  logic [SET_W-1:0]            up_set;
  logic [WAY_W-1:0]            up_way;
  logic                        up_hit;
  logic [TMC_W-1:0]            tmc_inc;
  bk_op_e                      op;
  logic                        promote;

  assign up_pset = up_pc[IDX_LO +: SET_W];
  assign up_tag  = up_pc[PC_W-1 -: TAG_W];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      up_vvec[w] = vld_q[up_pset][w];
      up_tvec[w] = tag_q[up_pset][w];
    end
  end

  btb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_up_match (
    .vld(up_vvec), .tags(up_tvec), .tag(up_tag),
    .hit(up_mhit), .hit_way(up_mway)
  );

  // next-state decode for the resolve port
  always_comb begin
    if (up_rh_en) begin
      up_set = up_rh_set;
      up_way = up_rh_way;
      up_hit = vld_q[up_rh_set][up_rh_way] && (tag_q[up_rh_set][up_rh_way] == up_tag);
    end else begin
      up_set = up_pset;
      up_way = up_mhit ? up_mway : victim;
      up_hit = up_mhit;
    end
    tmc_inc = tmc_q[up_set][up_way] + 1'b1;
    op      = BK_IDLE;
    promote = 1'b0;
    if (up_valid) begin
      if (up_hit) begin
        if (up_taken && (tgt_q[up_set][up_way] != up_target)) begin
          op      = BK_RETARGET;
          promote = (tmc_inc == TMC_W'(PROMO_THRESH));
        end else begin
          op = BK_HIT;
        end
      end else if (up_taken && !up_promoted) begin
        op = BK_FILL;
      end
    end
  end

  // write enables and data, derived from the decoded operation
  logic             st_en;      // valid/counter write
  logic             st_vld;
  logic [TMC_W-1:0] st_tmc;
  logic             tg_en;      // target write
  logic             fl_en;      // tag/type write
  logic             lru_touch;

  always_comb begin
    st_en     = 1'b0;
    st_vld    = 1'b0;
    st_tmc    = '0;
    tg_en     = 1'b0;
    fl_en     = 1'b0;
    lru_touch = 1'b0;
    case (op)
      BK_HIT: lru_touch = 1'b1;
      BK_RETARGET: begin
        st_en = 1'b1;
        if (promote) begin
          st_vld = 1'b0;              // free the entry, counter back to zero
          st_tmc = '0;
        end else begin
          st_vld    = 1'b1;
          st_tmc    = tmc_inc;
          tg_en     = 1'b1;
          lru_touch = 1'b1;
        end
      end
      BK_FILL: begin
        st_en     = 1'b1;
        st_vld    = 1'b1;
        st_tmc    = '0;
        tg_en     = 1'b1;
        fl_en     = 1'b1;
        lru_touch = 1'b1;
      end
      default: ;
    endcase
  end

  btb_lru_bank #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .rd_set(up_pset), .victim_way(victim),
    .touch_en(lru_touch), .touch_set(up_set), .touch_way(up_way)
  );

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          tmc_q[s][w] <= '0;
        end
    end else if (st_en) begin
      vld_q[up_set][up_way] <= st_vld;
      tmc_q[up_set][up_way] <= st_tmc;
    end
  end

  always_ff @(posedge clk) begin
    if (tg_en) tgt_q[up_set][up_way] <= up_target;
    if (fl_en) begin
      tag_q[up_set][up_way] <= up_tag;
      ind_q[up_set][up_way] <= up_indirect;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pm_valid <= 1'b0;
    else        pm_valid <= promote;
  end

  always_ff @(posedge clk) begin
    if (promote) begin
      pm_tag    <= tag_q[up_set][up_way];
      pm_target <= up_target;
    end
  end

  // ---------------- assertion support ----------------
  bk_op_e           chk_op_q;
  logic             chk_prom_q;
  logic [SET_W-1:0] chk_set_q;
  logic [WAY_W-1:0] chk_way_q;
  logic [TMC_W-1:0] chk_tmc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_op_q   <= BK_IDLE;
      chk_prom_q <= 1'b0;
    end else begin
      chk_op_q   <= op;
      chk_prom_q <= promote;
    end
  end

  always_ff @(posedge clk) begin
    chk_set_q <= up_set;
    chk_way_q <= up_way;
    chk_tmc_q <= tmc_q[up_set][up_way];
  end

  // R3: a retarget without promotion raises the stored counter by one
  p_retarget_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_op_q == BK_RETARGET && !chk_prom_q) |->
      (vld_q[chk_set_q][chk_way_q] && tmc_q[chk_set_q][chk_way_q] == chk_tmc_q + 1'b1));

  // R4: a promotion shows on the port and leaves a free, zeroed entry
  p_promo_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_prom_q |-> (pm_valid && !vld_q[chk_set_q][chk_way_q] &&
                    tmc_q[chk_set_q][chk_way_q] == '0));

  // R5: an always-taken indication only comes with a hit
  p_ind_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_always_taken |-> lk_hit);

  // R7: a branch held by the promotion buffer is never allocated
  p_no_realloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_promoted) |-> (op != BK_FILL));

  // R9: a fill leaves a valid entry with a zero counter
  p_fill_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_op_q == BK_FILL) |->
      (vld_q[chk_set_q][chk_way_q] && tmc_q[chk_set_q][chk_way_q] == '0));

endmodule

// File: tb/btb_promo_bench.sv
module btb_promo_bench;

  localparam int PC_W   = 32;
  localparam int SETS   = 8;
  localparam int WAYS   = 4;
  localparam int THRESH = 16;
  localparam int SET_W  = 3;
  localparam int WAY_W  = 2;
  localparam int TAG_W  = PC_W - 2 - SET_W;

  logic             clk;
  logic             rst_n;
  logic [PC_W-1:0]  lk_pc;
  logic             lk_rh_en;
  logic [SET_W-1:0] lk_rh_set;
  logic [WAY_W-1:0] lk_rh_way;
  logic             lk_hit;
  logic             lk_always_taken;
  logic [PC_W-1:0]  lk_target;
  logic             up_valid;
  logic [PC_W-1:0]  up_pc;
  logic [PC_W-1:0]  up_target;
  logic             up_taken;
  logic             up_indirect;
  logic             up_promoted;
  logic             up_rh_en;
  logic [SET_W-1:0] up_rh_set;
  logic [WAY_W-1:0] up_rh_way;
  logic             pm_valid;
  logic [TAG_W-1:0] pm_tag;
  logic [PC_W-1:0]  pm_target;

  btb_promo #(.PC_W(PC_W), .SETS(SETS), .WAYS(WAYS), .PROMO_THRESH(THRESH)) u_btb_promo (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_rh_en(lk_rh_en), .lk_rh_set(lk_rh_set), .lk_rh_way(lk_rh_way),
    .lk_hit(lk_hit), .lk_always_taken(lk_always_taken), .lk_target(lk_target),
    .up_valid(up_valid), .up_pc(up_pc), .up_target(up_target), .up_taken(up_taken),
    .up_indirect(up_indirect), .up_promoted(up_promoted), .up_rh_en(up_rh_en),
    .up_rh_set(up_rh_set), .up_rh_way(up_rh_way),
    .pm_valid(pm_valid), .pm_tag(pm_tag), .pm_target(pm_target)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  // captured after each update edge
  logic             o_pv;
  logic [TAG_W-1:0] o_ptag;
  logic [PC_W-1:0]  o_ptgt;
  // captured after each lookup
  logic             o_hit;
  logic             o_at;
  logic [PC_W-1:0]  o_tgt;

  function automatic logic [PC_W-1:0] mkpc(input int tag, input int set);
    return {TAG_W'(tag), SET_W'(set), 2'b00};
  endfunction

  task automatic check(input bit ok, input string req, input logic [PC_W-1:0] act,
                       input logic [PC_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tgt,
                     input bit taken, input bit ind, input bit prom,
                     input bit rh, input int rset, input int rway);
    @(negedge clk);
    up_pc = pc; up_target = tgt; up_taken = taken; up_indirect = ind;
    up_promoted = prom; up_rh_en = rh; up_rh_set = SET_W'(rset); up_rh_way = WAY_W'(rway);
    up_valid = 1'b1;
    @(negedge clk);
    up_valid = 1'b0; up_rh_en = 1'b0; up_promoted = 1'b0;
    o_pv = pm_valid; o_ptag = pm_tag; o_ptgt = pm_target;
  endtask

  task automatic lkp(input logic [PC_W-1:0] pc, input bit rh, input int rset, input int rway);
    lk_pc = pc; lk_rh_en = rh; lk_rh_set = SET_W'(rset); lk_rh_way = WAY_W'(rway);
    #1;
    o_hit = lk_hit; o_at = lk_always_taken; o_tgt = lk_target;
    lk_rh_en = 1'b0;
  endtask

  task automatic t_reset();
    for (int s = 0; s < SETS; s += 3) begin
      lkp(mkpc(s + 7, s), 0, 0, 0);
      check(!o_hit && o_tgt == '0, "R1 miss after reset", {31'd0, o_hit}, 0);
    end
    check(pm_valid == 1'b0, "R1 promotion low after reset", {31'd0, pm_valid}, 0);
  endtask

  task automatic t_fill_lookup();
    upd(mkpc(40, 0), 32'h0000_1230, 1, 0, 0, 0, 0, 0);
    lkp(mkpc(40, 0), 0, 0, 0);
    check(o_hit && o_tgt == 32'h0000_1230, "R2 R9 fill then hit target", o_tgt, 32'h1230);
    check(!o_at, "R5 conditional entry not always-taken", {31'd0, o_at}, 0);
    lkp(mkpc(41, 0), 0, 0, 0);
    check(!o_hit, "R2 other tag same set misses", {31'd0, o_hit}, 0);
    upd(mkpc(42, 6), 32'h0000_4440, 1, 1, 0, 0, 0, 0);
    lkp(mkpc(42, 6), 0, 0, 0);
    check(o_hit && o_at, "R5 indirect entry always-taken", {31'd0, o_at}, 1);
  endtask

  task automatic t_no_alloc();
    upd(mkpc(20, 3), 32'h0000_5000, 0, 0, 0, 0, 0, 0);
    lkp(mkpc(20, 3), 0, 0, 0);
    check(!o_hit, "R10 not-taken miss allocates nothing", {31'd0, o_hit}, 0);
    upd(mkpc(21, 3), 32'h0000_5100, 1, 1, 1, 0, 0, 0);
    lkp(mkpc(21, 3), 0, 0, 0);
    check(!o_hit, "R7 promoted branch not allocated", {31'd0, o_hit}, 0);
  endtask

  task automatic t_lru();
    for (int t = 11; t <= 14; t++) upd(mkpc(t, 1), 32'h100 * t, 1, 0, 0, 0, 0, 0);
    upd(mkpc(11, 1), 32'h100 * 11, 1, 0, 0, 0, 0, 0);   // touch, same target
    upd(mkpc(15, 1), 32'h100 * 15, 1, 0, 0, 0, 0, 0);   // evicts tag 12
    lkp(mkpc(12, 1), 0, 0, 0);
    check(!o_hit, "R8 least recent tag evicted", {31'd0, o_hit}, 0);
    for (int t = 11; t <= 15; t++) begin
      if (t != 12) begin
        lkp(mkpc(t, 1), 0, 0, 0);
        check(o_hit && o_tgt == 32'h100 * t, "R8 survivors still hit", o_tgt, 32'h100 * t);
      end
    end
  endtask

  task automatic t_promote();
    int pulses;
    logic [PC_W-1:0] pc;
    pc = mkpc(100, 4);
    upd(pc, 32'h0000_1000, 1, 1, 0, 0, 0, 0);
    pulses = 0;
    for (int i = 1; i < THRESH; i++) begin
      upd(pc, 32'h0000_2000 + 32'(i * 4), 1, 1, 0, 0, 0, 0);
      if (o_pv) pulses++;
    end
    lkp(pc, 0, 0, 0);
    check(o_hit && o_tgt == 32'h2000 + 32'((THRESH - 1) * 4), "R3 target replaced",
          o_tgt, 32'h2000 + 32'((THRESH - 1) * 4));
    for (int i = 0; i < 3; i++) begin       // correct-target hits do not count
      upd(pc, 32'h2000 + 32'((THRESH - 1) * 4), 1, 1, 0, 0, 0, 0);
      if (o_pv) pulses++;
    end
    check(pulses == 0, "R3 no promotion below threshold", 32'(pulses), 0);
    upd(pc, 32'h0000_3000, 1, 1, 0, 0, 0, 0);
    check(o_pv == 1'b1, "R4 promotion at threshold", {31'd0, o_pv}, 1);
    check(o_ptag == TAG_W'(100), "R4 promoted tag", 32'(o_ptag), 100);
    check(o_ptgt == 32'h0000_3000, "R4 promoted target", o_ptgt, 32'h3000);
    lkp(pc, 0, 0, 0);
    check(!o_hit, "R4 entry freed", {31'd0, o_hit}, 0);
    @(negedge clk);
    check(pm_valid == 1'b0, "R4 promotion lasts one cycle", {31'd0, pm_valid}, 0);
    // refill: counter must restart from zero
    upd(pc, 32'h0000_6000, 1, 1, 0, 0, 0, 0);
    pulses = 0;
    for (int i = 1; i < THRESH; i++) begin
      upd(pc, 32'h0000_7000 + 32'(i * 4), 1, 1, 0, 0, 0, 0);
      if (o_pv) pulses++;
    end
    check(pulses == 0, "R4 R9 counter cleared by promotion", 32'(pulses), 0);
    upd(pc, 32'h0000_8000, 1, 1, 0, 0, 0, 0);
    check(o_pv == 1'b1, "R4 second promotion after full count", {31'd0, o_pv}, 1);
  endtask

  task automatic t_rehash();
    logic [PC_W-1:0] pc;
    pc = mkpc(30, 2);
    upd(pc, 32'h0000_9000, 1, 0, 0, 1, 5, 1);
    lkp(pc, 1, 5, 1);
    check(o_hit && o_tgt == 32'h9000, "R6 rehashed hit", o_tgt, 32'h9000);
    lkp(pc, 1, 5, 0);
    check(!o_hit, "R6 other way misses", {31'd0, o_hit}, 0);
    lkp(pc, 0, 0, 0);
    check(!o_hit, "R6 plain lookup misses", {31'd0, o_hit}, 0);
    upd(pc, 32'h0000_9800, 1, 0, 0, 1, 5, 1);
    lkp(pc, 1, 5, 1);
    check(o_hit && o_tgt == 32'h9800, "R6 R3 rehashed retarget", o_tgt, 32'h9800);
  endtask

  initial begin
    rst_n = 1'b0;
    lk_pc = '0; lk_rh_en = 0; lk_rh_set = '0; lk_rh_way = '0;
    up_valid = 0; up_pc = '0; up_target = '0; up_taken = 0; up_indirect = 0;
    up_promoted = 0; up_rh_en = 0; up_rh_set = '0; up_rh_way = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_lookup();
    t_no_alloc();
    t_lru();
    t_promote();
    t_rehash();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule